// File: doc/BRIEF.md
# PLL Divider Setting Calculator

This block turns a requested output frequency into the two settings a fractional-N PLL needs: a power-of-two post-divider exponent, and a fixed-point feedback divider word. A request carries four values: the target frequency, the reference frequency, the highest frequency the PLL may produce, and the width of the divider word. The frequencies are unsigned integers in Hz. The block first limits the target to the maximum. It then walks up the post-divider exponents until the VCO, which runs at target × 2^exp, reaches the 1 GHz floor. Last, it forms the divider word with a bit-serial long division.

The block is built around a four-state machine:
- `ST_IDLE`: waits for `start_i` and latches the request.
- `ST_CLAMP`: limits the target and derives the number of fractional bits. It also catches a zero reference, which sends the machine straight back to `ST_IDLE` with an error.
- `ST_SEARCH`: tests one exponent per cycle. When an exponent meets the floor, or when the last exponent is reached, it loads the divider and moves to `ST_DIVIDE`.
- `ST_DIVIDE`: produces one quotient bit per cycle for 64 cycles, then returns to `ST_IDLE` and publishes the result with a one-cycle `done_o`.

Results stay on the outputs until the next request completes.

Top module: `pll_setting_calc`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0, and word_o and exp_o are 0.
- R2: A target above fmax_i is replaced by fmax_i before the exponent search and the division use it.
- R3: exp_o is the smallest value in 0..4 for which target × 2^exp_o ≥ 1,000,000,000, where target is the clamped target. If no value in that range meets this, exp_o is 4.
- R4: The number of fractional bits is word_bits_i − 7 when word_bits_i is greater than 7, and 0 otherwise.
- R5: word_o is the low 32 bits of ((target << exp_o) << fractional bits) / ref_i. The dividend is formed in 64 bits, and the quotient is truncated toward zero.
- R6: A start accepted at clock edge k raises busy_o after edge k. For a nonzero reference, done_o is high for exactly one cycle after edge k+66+exp_o, and busy_o falls at that same edge.
- R7: A reference of zero makes done_o and err_o high after edge k+1, with word_o = 0 and exp_o = 0. No division is performed.
- R8: start_i is ignored while busy_o is high: the running request completes with its own result and no second run follows.
- R9: word_o, exp_o and err_o hold their values between completions. A successful completion clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a calculation (accepted only when idle) |
| target_i | input | 32 | Requested output frequency in Hz |
| ref_i | input | 32 | Reference frequency in Hz |
| fmax_i | input | 32 | Highest allowed output frequency in Hz |
| word_bits_i | input | 6 | Divider word width; 7 integer bits, rest fractional |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when a result is published |
| err_o | output | 1 | Last request had a zero reference |
| word_o | output | 32 | Feedback divider word |
| exp_o | output | 3 | Post-divider exponent (divide by 2^exp_o) |

## Verification
The result of a valid request is due 66+exp_o edges after the start edge. A zero-reference error is due one edge after the start edge. The bench model computes the exponent as soon as a request is accepted, so it knows the exact latency. It then counts clock edges from acceptance and predicts busy_o and done_o for every cycle. The published word, exponent and error flag are checked on every cycle, half a period after each edge, against the values the model holds. This also confirms that results stay unchanged between completions and that a start issued mid-run has no effect.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLAMP  = 2'd1,
        ST_SEARCH = 2'd2,
        ST_DIVIDE = 2'd3
    } calc_state_e;

endpackage

// File: rtl/pllcalc_clamp.sv
module pllcalc_clamp #(
    parameter int W = 32
) (
    input  logic [W-1:0] value_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] value_o
);

    always_comb begin
        if (value_i > limit_i) begin
            value_o = limit_i;
        end else begin
            value_o = value_i;
        end
    end

endmodule

// File: rtl/pllcalc_floor.sv
module pllcalc_floor #(
    parameter int          FREQ_W  = 32,
    parameter int          EXP_MAX = 4,
    parameter logic [63:0] VCO_MIN = 64'd1_000_000_000
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic [EXP_MAX:0]  meets_o
);

    localparam int EXT_W = FREQ_W + EXP_MAX;
    localparam logic [EXT_W-1:0] FLOOR = EXT_W'(VCO_MIN);

    logic [EXT_W-1:0] freq_ext;
    assign freq_ext = {{EXP_MAX{1'b0}}, freq_i};

    for (genvar g = 0; g <= EXP_MAX; g++) begin : g_cand
        logic [EXT_W-1:0] vco;
        assign vco        = freq_ext << g;
        assign meets_o[g] = (vco >= FLOOR);
    end

endmodule

// File: rtl/pllcalc_divider.sv
module pllcalc_divider #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32,
    parameter int QUO_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    input  logic             step_i,
    output logic             last_o,
    output logic [QUO_W-1:0] quo_nxt_o
);

    localparam int CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DVD_W - 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W:0]   rem_q;
    logic [QUO_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;

    logic [DVS_W:0]   rem_sh;
    logic [DVS_W:0]   dvs_ext;
    logic             fits;
    logic [DVS_W:0]   rem_nx;

    always_comb begin
        rem_sh  = {rem_q[DVS_W-1:0], dvd_q[DVD_W-1]};
        dvs_ext = {1'b0, dvs_q};
        fits    = (rem_sh >= dvs_ext);
        rem_nx  = fits ? (rem_sh - dvs_ext) : rem_sh;
    end

    assign quo_nxt_o = {quo_q[QUO_W-2:0], fits};
    assign last_o    = (cnt_q == LAST_CNT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dvd_q <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            dvd_q <= dividend_i;
            dvs_q <= divisor_i;
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
        end else if (step_i) begin
            dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
            rem_q <= rem_nx;
            quo_q <= quo_nxt_o;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> (rem_q < {1'b0, dvs_q}));

    // R5
    step_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !last_o) |=> (load_i || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pll_setting_calc.sv
module pll_setting_calc
    import pllcalc_pkg::*;
#(
    parameter int          FREQ_W   = 32,
    parameter int          WORD_W   = 32,
    parameter int          WBITS_W  = 6,
    parameter int          EXP_MAX  = 4,
    parameter int          INT_BITS = 7,
    parameter int          DVD_W    = 64,
    parameter logic [63:0] VCO_MIN  = 64'd1_000_000_000,
    localparam int         EXP_W    = $clog2(EXP_MAX + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [FREQ_W-1:0]  target_i,
    input  logic [FREQ_W-1:0]  ref_i,
    input  logic [FREQ_W-1:0]  fmax_i,
    input  logic [WBITS_W-1:0] word_bits_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [WORD_W-1:0]  word_o,
    output logic [EXP_W-1:0]   exp_o
);

    localparam logic [EXP_W-1:0]   EXP_TOP = EXP_W'(EXP_MAX);
    localparam logic [WBITS_W-1:0] INT_W   = WBITS_W'(INT_BITS);

    calc_state_e state_q, state_d;

    logic [FREQ_W-1:0]  tgt_q;
    logic [FREQ_W-1:0]  ref_q;
    logic [FREQ_W-1:0]  fmax_q;
    logic [WBITS_W-1:0] wbits_q;
    logic [WBITS_W-1:0] frac_q;
    logic [EXP_W-1:0]   exp_q;

    logic [FREQ_W-1:0]  tgt_clamped;
    logic [WBITS_W-1:0] frac_calc;
    logic [EXP_MAX:0]   meets;
    logic               hit;
    logic               ref_zero;
    logic [DVD_W-1:0]   dvd_init;
    logic               div_load;
    logic               div_step;
    logic               div_last;
    logic [WORD_W-1:0]  quo_nxt;

    pllcalc_clamp #(
        .W (FREQ_W)
    ) u_clamp (
        .value_i (tgt_q),
        .limit_i (fmax_q),
        .value_o (tgt_clamped)
    );

    pllcalc_floor #(
        .FREQ_W  (FREQ_W),
        .EXP_MAX (EXP_MAX),
        .VCO_MIN (VCO_MIN)
    ) u_floor (
        .freq_i  (tgt_q),
        .meets_o (meets)
    );

    pllcalc_divider #(
        .DVD_W (DVD_W),
        .DVS_W (FREQ_W),
        .QUO_W (WORD_W)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (div_load),
        .dividend_i (dvd_init),
        .divisor_i  (ref_q),
        .step_i     (div_step),
        .last_o     (div_last),
        .quo_nxt_o  (quo_nxt)
    );

    always_comb begin
        frac_calc = (wbits_q > INT_W) ? (wbits_q - INT_W) : '0;
        ref_zero  = (ref_q == '0);
        hit       = meets[exp_q] || (exp_q == EXP_TOP);
        dvd_init  = (DVD_W'(tgt_q) << exp_q) << frac_q;
        div_load  = (state_q == ST_SEARCH) && hit;
        div_step  = (state_q == ST_DIVIDE);
        busy_o    = (state_q != ST_IDLE);
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)  state_d = ST_CLAMP;
            ST_CLAMP:  state_d = ref_zero ? ST_IDLE : ST_SEARCH;
            ST_SEARCH: if (hit)      state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tgt_q   <= '0;
            ref_q   <= '0;
            fmax_q  <= '0;
            wbits_q <= '0;
            frac_q  <= '0;
            exp_q   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            word_o  <= '0;
            exp_o   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tgt_q   <= target_i;
                        ref_q   <= ref_i;
                        fmax_q  <= fmax_i;
                        wbits_q <= word_bits_i;
                    end
                end
                ST_CLAMP: begin
                    tgt_q  <= tgt_clamped;
                    frac_q <= frac_calc;
                    exp_q  <= '0;
                    if (ref_zero) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                        word_o <= '0;
                        exp_o  <= '0;
                    end
                end
                ST_SEARCH: begin
                    if (!hit) begin
                        exp_q <= exp_q + 1'b1;
                    end
                end
                ST_DIVIDE: begin
                    if (div_last) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b0;
                        word_o <= quo_nxt;
                        exp_o  <= exp_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R6
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    // R8
    start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !div_last && state_q != ST_CLAMP) |=> busy_o);

    // R3
    exp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exp_q <= EXP_TOP);

    // R2
    clamp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH) |-> (tgt_q <= fmax_q));

    // R7
    err_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o) |-> (word_o == '0 && exp_o == '0));

    // R9
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(done_o) && !done_o) |-> ($stable(word_o) && $stable(err_o)));

endmodule

// File: tb/pll_setting_calc_tb.sv
module pll_setting_calc_tb;

    localparam int CLK_PERIOD = 10;
    localparam longint unsigned FLOOR_HZ = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target = '0;
    logic [31:0] refclk = '0;
    logic [31:0] fmax = '0;
    logic [5:0]  wbits = '0;
    logic        busy, done, err;
    logic [31:0] word;
    logic [2:0]  expo;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // reference model state
    bit               m_busy = 0, m_done = 0, m_err = 0;
    int               m_cnt = 0, m_lat = 0;
    longint unsigned  m_word = 0, p_word = 0;
    int               m_exp = 0, p_exp = 0;
    bit               p_err = 0;
    bit               acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_setting_calc u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .target_i    (target),
        .ref_i       (refclk),
        .fmax_i      (fmax),
        .word_bits_i (wbits),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .word_o      (word),
        .exp_o       (expo)
    );

    function automatic int pick_exp(longint unsigned t);
        for (int k = 0; k <= 4; k++) begin
            if ((t << k) >= FLOOR_HZ) return k;
        end
        return 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_word = 0; m_exp = 0;
        end else begin
            acc    = start && !m_busy;
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == m_lat) begin
                    m_busy = 0; m_done = 1;
                    m_word = p_word; m_exp = p_exp; m_err = p_err;
                end
            end
            if (acc) begin
                longint unsigned t, r, fr, dv;
                t  = (target > fmax) ? longint'(fmax) : longint'(target);
                r  = longint'(refclk);
                fr = (wbits > 7) ? longint'(wbits - 7) : 0;
                if (r == 0) begin
                    p_err = 1; p_word = 0; p_exp = 0; m_lat = 1;
                end else begin
                    p_err  = 0;
                    p_exp  = pick_exp(t);
                    dv     = (t << p_exp) << fr;
                    p_word = (dv / r) & 64'hFFFF_FFFF;
                    m_lat  = 66 + p_exp;
                end
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    task automatic chk(string what, longint unsigned act, longint unsigned expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("busy (R6)", busy, m_busy);
            chk("done (R6)", done, m_done);
            chk("word (R5)", word, m_word);
            chk("exp (R3)", expo, m_exp);
            chk("err (R7)", err, m_err);
        end
    end

    task automatic launch(longint unsigned t, longint unsigned r,
                          longint unsigned f, int w);
        @(negedge clk);
        target = t[31:0]; refclk = r[31:0]; fmax = f[31:0]; wbits = w[5:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(string req, longint unsigned t, longint unsigned r,
                       longint unsigned f, int w);
        cur_req = req;
        launch(t, r, f, w);
        finish_run();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            report();
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);   // R1 reset values compared by the per-cycle checks
        run("R3", 64'd1_500_000_000, 64'd26_000_000, 64'd3_800_000_000, 32);
        run("R3", 64'd300_000_000,   64'd26_000_000, 64'd3_800_000_000, 32);
        run("R3", 64'd50_000_000,    64'd26_000_000, 64'd3_800_000_000, 32);
        run("R3", 64'd62_500_000,    64'd26_000_000, 64'd3_800_000_000, 32);
        run("R3", 64'd500_000_000,   64'd25_000_000, 64'd3_800_000_000, 24);
        run("R2", 64'd4_000_000_000, 64'd26_000_000, 64'd3_000_000_000, 32);
        run("R2", 64'd900_000_000,   64'd26_000_000, 64'd400_000_000,   30);
        run("R4", 64'd700_000_000,   64'd13_000_000, 64'd3_800_000_000, 7);
        run("R4", 64'd700_000_000,   64'd13_000_000, 64'd3_800_000_000, 3);
        run("R4", 64'd1_234_567_891, 64'd19_200_000, 64'd3_800_000_000, 8);
        run("R5", 64'd2_000_000_000, 64'd1,          64'd3_800_000_000, 32);
        run("R5", 64'd1_000_000_001, 64'd3,          64'd4_000_000_000, 20);
        run("R7", 64'd800_000_000,   64'd0,          64'd3_800_000_000, 32);
        run("R9", 64'd800_000_000,   64'd26_000_000, 64'd3_800_000_000, 32);
        // R8: a second start during a run must not change the result or add a run
        cur_req = "R8";
        launch(64'd300_000_000, 64'd26_000_000, 64'd3_800_000_000, 32);
        repeat (10) @(negedge clk);
        launch(64'd1_900_000_000, 64'd7_000_000, 64'd3_800_000_000, 20);
        repeat (30) @(negedge clk);
        launch(64'd0, 64'd0, 64'd0, 0);
        finish_run();
        // R6: back-to-back request launched on the cycle done is visible
        cur_req = "R6";
        launch(64'd80_000_000, 64'd26_000_000, 64'd3_800_000_000, 28);
        while (!m_done) @(negedge clk);
        start = 1'b1; target = 32'd1_100_000_000; refclk = 32'd26_000_000;
        @(negedge clk);
        start = 1'b0;
        finish_run();
        report();
    end

endmodule